// File: doc/BRIEF.md
# Linked-List DMA Channel Engine

A single DMA channel that moves 32-bit words between a byte-addressed word memory port and a peripheral port. Software programs three registers: a base address, a block-control word holding the word count, and a channel-control word. The channel-control word selects the direction, the address step and the synchronisation mode. Setting its enable and start bits launches a transfer.

Manual block mode moves a fixed number of words in either direction. The address steps up or down by 4 and wraps inside a 24-bit space. Linked-list mode runs from memory to device only. The engine reads a header word that holds a payload count and the address of the next node. It streams that node's payload to the device, then either follows the pointer or stops when the pointer's end-marker bit is set. Every word sent to the device carries the number of words still to come in its block or node.

The memory port is a valid/ready request channel plus a read-return strobe. The device side has a transmit channel and a receive channel, each a valid/ready word handshake. The modes the engine does not run are still decoded, and they end at once with an error flag.

Top module: `chain_dma_engine`

## Requirements
- R1: Register select codes are 0 = base address, 1 = block control, 2 = channel control. A write to the base keeps only bits 23:0. `reg_rdata` shows the register named by `reg_sel` one cycle later, with unused bits reading 0.
- R2: A transfer begins when channel-control bit 24 (enable) and bit 28 (start) are both 1 while the engine is idle. Start reads 0 from then on, `busy` is 1 during the transfer, and enable reads 0 once it ends.
- R3: In manual mode (channel-control bits 10:9 = 0) with bit 0 = 1 (memory to device), the engine reads exactly N words. N is block-control bits CNT_W-1:0, and a value of 0 means 2^CNT_W words. Reading starts at the base with bits 1:0 cleared. The address then steps by +4, or by -4 when bit 1 is 1, and wraps within 24 bits.
- R4: In manual mode with bit 0 = 0 (device to memory), each received device word is written to memory at the same address sequence as in R3, N words in total.
- R5: Each word on the device transmit port comes with `dev_tx_remain`, the number of words still to go after it in the current block or node.
- R6: In linked-list mode (bits 10:9 = 2) the engine reads the header at the base. Header bits 31:24 are the payload count and bits 23:0 the next pointer. The payload starts at header address + 4 and always steps +4, whatever bit 1 holds.
- R7: A header with a count of 0 moves no payload, and its pointer is still followed.
- R8: When bit 23 of the pointer is 1, the transfer ends after that node. Otherwise the next header is read at the pointer with bits 1:0 cleared.
- R9: Mode 1, mode 3, or mode 2 with bit 0 = 0 moves no data, sets `err`, and still clears enable. `err` stays 1 until the next transfer begins.
- R10: The chopping enable (bit 8) and window (bits 18:16) are stored and read back, and have no effect on a transfer.
- R11: Register writes while `busy` is 1 are ignored.
- R12: Once `mem_valid` or `dev_tx_valid` is raised, the request and its payload hold steady until accepted, and the engine never drives both at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select for write and readback |
| reg_wdata | input | DW | Register write data |
| reg_rdata | output | DW | Registered readback of the selected register |
| mem_valid | output | 1 | Memory request valid |
| mem_ready | input | 1 | Memory request accepted |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | AW | Byte address, word aligned |
| mem_wdata | output | DW | Write data |
| mem_rvalid | input | 1 | Read data return strobe |
| mem_rdata | input | DW | Read data |
| dev_tx_valid | output | 1 | Word to device valid |
| dev_tx_ready | input | 1 | Device accepts word |
| dev_tx_data | output | DW | Word to device |
| dev_tx_remain | output | CNT_W | Words still to go after this one |
| dev_rx_valid | input | 1 | Device offers a word |
| dev_rx_ready | output | 1 | Engine accepts device word |
| dev_rx_data | input | DW | Word from device |
| busy | output | 1 | Transfer in progress |
| err | output | 1 | Last transfer used an unsupported mode |

## Verification
The assertions assume that memory returns exactly one `mem_rvalid` for each accepted read, and never before the read is accepted. They also assume that `mem_ready` and `dev_tx_ready` are free to stall for any number of cycles. The bench's memory model answers every accepted read one cycle later, and it raises no unsolicited strobes. It toggles both ready signals in fixed patterns so that the hold checks are exercised. Registers are written only while the engine is idle, except in the one test that writes during a transfer on purpose.

// File: rtl/dma_eng_pkg.sv
package dma_eng_pkg;
  typedef enum logic [1:0] {
    MODE_MANUAL  = 2'd0,
    MODE_REQUEST = 2'd1,
    MODE_LIST    = 2'd2,
    MODE_RSVD    = 2'd3
  } sync_mode_e;

  typedef enum logic [3:0] {
    S_IDLE, S_HDR_REQ, S_HDR_WAIT, S_RD_REQ, S_RD_WAIT,
    S_TX, S_RX, S_WR_REQ, S_FIN
  } eng_state_e;

  localparam int SEL_BASE  = 0;
  localparam int SEL_BLOCK = 1;
  localparam int SEL_CTL   = 2;

  localparam int CTL_DIR     = 0;
  localparam int CTL_REV     = 1;
  localparam int CTL_CHOP    = 8;
  localparam int CTL_MODE_LO = 9;
  localparam int CTL_WIN_LO  = 16;
  localparam int CTL_EN      = 24;
  localparam int CTL_START   = 28;
endpackage

// File: rtl/dma_regs.sv
module dma_regs
  import dma_eng_pkg::*;
#(
  parameter int AW    = 24,
  parameter int DW    = 32,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [1:0]       sel,
  input  logic [DW-1:0]    wr_data,
  input  logic             lock,
  input  logic             clr_start,
  input  logic             clr_enable,
  output logic [AW-1:0]    base_q,
  output logic [CNT_W-1:0] count_q,
  output logic             dir_to_dev,
  output logic             step_rev,
  output sync_mode_e       mode_q,
  output logic             enable_q,
  output logic             start_q,
  output logic [DW-1:0]    rd_data
);
  logic       chop_q;
  logic [2:0] win_q;
  logic [DW-1:0] ctl_view;
  logic       wr_ok;

  assign wr_ok = wr_en && !lock;

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q     <= '0;
      count_q    <= '0;
      dir_to_dev <= 1'b0;
      step_rev   <= 1'b0;
      mode_q     <= MODE_MANUAL;
      chop_q     <= 1'b0;
      win_q      <= '0;
      enable_q   <= 1'b0;
      start_q    <= 1'b0;
    end else begin
      if (wr_ok && sel == 2'(SEL_BASE))  base_q  <= wr_data[AW-1:0];
      if (wr_ok && sel == 2'(SEL_BLOCK)) count_q <= wr_data[CNT_W-1:0];
      if (wr_ok && sel == 2'(SEL_CTL)) begin
        dir_to_dev <= wr_data[CTL_DIR];
        step_rev   <= wr_data[CTL_REV];
        chop_q     <= wr_data[CTL_CHOP];
        mode_q     <= sync_mode_e'(wr_data[CTL_MODE_LO +: 2]);
        win_q      <= wr_data[CTL_WIN_LO +: 3];
        enable_q   <= wr_data[CTL_EN];
        start_q    <= wr_data[CTL_START];
      end
      if (clr_start)  start_q  <= 1'b0;
      if (clr_enable) enable_q <= 1'b0;
    end
  end

  always_comb begin
    ctl_view = '0;
    ctl_view[CTL_DIR]          = dir_to_dev;
    ctl_view[CTL_REV]          = step_rev;
    ctl_view[CTL_CHOP]         = chop_q;
    ctl_view[CTL_MODE_LO +: 2] = mode_q;
    ctl_view[CTL_WIN_LO +: 3]  = win_q;
    ctl_view[CTL_EN]           = enable_q;
    ctl_view[CTL_START]        = start_q;
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else begin
      case (sel)
        2'(SEL_BASE):  rd_data <= DW'(base_q);
        2'(SEL_BLOCK): rd_data <= DW'(count_q);
        2'(SEL_CTL):   rd_data <= ctl_view;
        default:       rd_data <= '0;
      endcase
    end
  end
endmodule

// File: rtl/dma_step.sv
module dma_step #(
  parameter int AW = 24
) (
  input  logic [AW-1:0] cur,
  input  logic          rev,
  output logic [AW-1:0] nxt
);
  localparam logic [AW-1:0] WORD_BYTES = AW'(4);
  assign nxt = rev ? (cur - WORD_BYTES) : (cur + WORD_BYTES);
endmodule

// File: rtl/dma_seq.sv
module dma_seq
  import dma_eng_pkg::*;
#(
  parameter int AW    = 24,
  parameter int DW    = 32,
  parameter int CNT_W = 16,
  parameter int HDR_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [AW-1:0]    base,
  input  logic [CNT_W-1:0] count,
  input  logic             dir_to_dev,
  input  logic             step_rev,
  input  sync_mode_e       mode,
  input  logic             enable,
  input  logic             start,
  output logic             clr_start,
  output logic             clr_enable,
  output logic             busy,
  output logic [AW-1:0]    cur_addr,
  output logic             cur_rev,
  input  logic [AW-1:0]    step_addr,
  output logic             mem_valid,
  input  logic             mem_ready,
  output logic             mem_we,
  output logic [AW-1:0]    mem_addr,
  output logic [DW-1:0]    mem_wdata,
  input  logic             mem_rvalid,
  input  logic [DW-1:0]    mem_rdata,
  output logic             tx_valid,
  input  logic             tx_ready,
  output logic [DW-1:0]    tx_data,
  output logic [CNT_W-1:0] tx_remain,
  input  logic             rx_valid,
  output logic             rx_ready,
  input  logic [DW-1:0]    rx_data,
  output logic             err
);
  localparam int RW = CNT_W + 1;
  localparam logic [RW-1:0] ONE = RW'(1);

  eng_state_e st;
  logic [RW-1:0] remain;
  logic [AW-1:0] next_ptr;
  logic          last_node;
  logic          list_mode;
  logic          go;
  logic [AW-1:0] base_al;
  logic [AW-1:0] hdr_ptr;
  logic [HDR_W-1:0] hdr_cnt;

  assign go         = (st == S_IDLE) && enable && start;
  assign clr_start  = go;
  assign clr_enable = (st == S_FIN);
  assign busy       = (st != S_IDLE);
  assign cur_addr   = st == S_IDLE ? base_al : mem_addr_src();
  assign cur_rev    = step_rev && !list_mode;
  assign base_al    = {base[AW-1:2], 2'b00};
  assign hdr_ptr    = {mem_rdata[AW-1:2], 2'b00};
  assign hdr_cnt    = mem_rdata[DW-1 -: HDR_W];

  logic [AW-1:0] addr_q;
  function automatic logic [AW-1:0] mem_addr_src();
    return addr_q;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= S_IDLE;
      addr_q    <= '0;
      remain    <= '0;
      next_ptr  <= '0;
      last_node <= 1'b0;
      list_mode <= 1'b0;
      mem_valid <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      tx_valid  <= 1'b0;
      tx_data   <= '0;
      tx_remain <= '0;
      rx_ready  <= 1'b0;
      err       <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (go) begin
          err       <= 1'b0;
          addr_q    <= base_al;
          list_mode <= (mode == MODE_LIST);
          remain    <= (count == '0) ? {1'b1, CNT_W'(0)} : {1'b0, count};
          if (mode == MODE_MANUAL && dir_to_dev) begin
            mem_valid <= 1'b1;
            mem_we    <= 1'b0;
            mem_addr  <= base_al;
            st        <= S_RD_REQ;
          end else if (mode == MODE_MANUAL) begin
            rx_ready <= 1'b1;
            st       <= S_RX;
          end else if (mode == MODE_LIST && dir_to_dev) begin
            mem_valid <= 1'b1;
            mem_we    <= 1'b0;
            mem_addr  <= base_al;
            st        <= S_HDR_REQ;
          end else begin
            err <= 1'b1;
            st  <= S_FIN;
          end
        end
        S_HDR_REQ: if (mem_ready) begin
          mem_valid <= 1'b0;
          st        <= S_HDR_WAIT;
        end
        S_HDR_WAIT: if (mem_rvalid) begin
          next_ptr  <= hdr_ptr;
          last_node <= mem_rdata[AW-1];
          remain    <= RW'(hdr_cnt);
          if (hdr_cnt != '0) begin
            addr_q    <= step_addr;
            mem_valid <= 1'b1;
            mem_addr  <= step_addr;
            st        <= S_RD_REQ;
          end else if (mem_rdata[AW-1]) begin
            st <= S_FIN;
          end else begin
            addr_q    <= hdr_ptr;
            mem_valid <= 1'b1;
            mem_addr  <= hdr_ptr;
            st        <= S_HDR_REQ;
          end
        end
        S_RD_REQ: if (mem_ready) begin
          mem_valid <= 1'b0;
          st        <= S_RD_WAIT;
        end
        S_RD_WAIT: if (mem_rvalid) begin
          tx_valid  <= 1'b1;
          tx_data   <= mem_rdata;
          tx_remain <= CNT_W'(remain - ONE);
          st        <= S_TX;
        end
        S_TX: if (tx_ready) begin
          tx_valid <= 1'b0;
          remain   <= remain - ONE;
          addr_q   <= step_addr;
          if (remain == ONE) begin
            if (list_mode && !last_node) begin
              addr_q    <= next_ptr;
              mem_valid <= 1'b1;
              mem_addr  <= next_ptr;
              st        <= S_HDR_REQ;
            end else begin
              st <= S_FIN;
            end
          end else begin
            mem_valid <= 1'b1;
            mem_addr  <= step_addr;
            st        <= S_RD_REQ;
          end
        end
        S_RX: if (rx_valid) begin
          rx_ready  <= 1'b0;
          mem_valid <= 1'b1;
          mem_we    <= 1'b1;
          mem_addr  <= addr_q;
          mem_wdata <= rx_data;
          st        <= S_WR_REQ;
        end
        S_WR_REQ: if (mem_ready) begin
          mem_valid <= 1'b0;
          mem_we    <= 1'b0;
          remain    <= remain - ONE;
          addr_q    <= step_addr;
          if (remain == ONE) st <= S_FIN;
          else begin
            rx_ready <= 1'b1;
            st       <= S_RX;
          end
        end
        S_FIN:   st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/chain_dma_engine.sv
module chain_dma_engine
  import dma_eng_pkg::*;
#(
  parameter int AW    = 24,
  parameter int DW    = 32,
  parameter int CNT_W = 16,
  parameter int HDR_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             reg_we,
  input  logic [1:0]       reg_sel,
  input  logic [DW-1:0]    reg_wdata,
  output logic [DW-1:0]    reg_rdata,
  output logic             mem_valid,
  input  logic             mem_ready,
  output logic             mem_we,
  output logic [AW-1:0]    mem_addr,
  output logic [DW-1:0]    mem_wdata,
  input  logic             mem_rvalid,
  input  logic [DW-1:0]    mem_rdata,
  output logic             dev_tx_valid,
  input  logic             dev_tx_ready,
  output logic [DW-1:0]    dev_tx_data,
  output logic [CNT_W-1:0] dev_tx_remain,
  input  logic             dev_rx_valid,
  output logic             dev_rx_ready,
  input  logic [DW-1:0]    dev_rx_data,
  output logic             busy,
  output logic             err
);
  logic [AW-1:0]    base_q;
  logic [CNT_W-1:0] count_q;
  logic             dir_to_dev, step_rev, enable_q, start_q;
  sync_mode_e       mode_q;
  logic             clr_start, clr_enable;
  logic [AW-1:0]    cur_addr, step_addr;
  logic             cur_rev;

  dma_regs #(.AW(AW), .DW(DW), .CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(reg_we), .sel(reg_sel), .wr_data(reg_wdata),
    .lock(busy), .clr_start(clr_start), .clr_enable(clr_enable),
    .base_q(base_q), .count_q(count_q), .dir_to_dev(dir_to_dev),
    .step_rev(step_rev), .mode_q(mode_q), .enable_q(enable_q),
    .start_q(start_q), .rd_data(reg_rdata)
  );

  dma_step #(.AW(AW)) u_step (
    .cur(cur_addr), .rev(cur_rev), .nxt(step_addr)
  );

  dma_seq #(.AW(AW), .DW(DW), .CNT_W(CNT_W), .HDR_W(HDR_W)) u_seq (
    .clk(clk), .rst(rst), .base(base_q), .count(count_q),
    .dir_to_dev(dir_to_dev), .step_rev(step_rev), .mode(mode_q),
    .enable(enable_q), .start(start_q), .clr_start(clr_start),
    .clr_enable(clr_enable), .busy(busy), .cur_addr(cur_addr),
    .cur_rev(cur_rev), .step_addr(step_addr),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rvalid(mem_rvalid),
    .mem_rdata(mem_rdata), .tx_valid(dev_tx_valid), .tx_ready(dev_tx_ready),
    .tx_data(dev_tx_data), .tx_remain(dev_tx_remain), .rx_valid(dev_rx_valid),
    .rx_ready(dev_rx_ready), .rx_data(dev_rx_data), .err(err)
  );
endmodule

// File: rtl/chain_dma_engine_chk.sv
module chain_dma_engine_chk #(
  parameter int AW    = 24,
  parameter int DW    = 32,
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             mem_valid,
  input logic             mem_ready,
  input logic             mem_we,
  input logic [AW-1:0]    mem_addr,
  input logic [DW-1:0]    mem_wdata,
  input logic             dev_tx_valid,
  input logic             dev_tx_ready,
  input logic [DW-1:0]    dev_tx_data,
  input logic [CNT_W-1:0] dev_tx_remain,
  input logic             dev_rx_ready,
  input logic             busy,
  input logic             err,
  input logic             start_bit
);
  p_mem_hold_r12: assert property (@(posedge clk) disable iff (rst)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));

  p_tx_hold_r12: assert property (@(posedge clk) disable iff (rst)
    dev_tx_valid && !dev_tx_ready |=> dev_tx_valid && $stable(dev_tx_data) && $stable(dev_tx_remain));

  p_one_port_r12: assert property (@(posedge clk) disable iff (rst)
    !(mem_valid && dev_tx_valid));

  p_aligned_r3: assert property (@(posedge clk) disable iff (rst)
    mem_valid |-> mem_addr[1:0] == 2'b00);

  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !mem_valid && !dev_tx_valid && !dev_rx_ready);

  p_start_cleared_r2: assert property (@(posedge clk) disable iff (rst)
    busy |-> !start_bit);

  p_err_nodata_r9: assert property (@(posedge clk) disable iff (rst)
    err |-> !mem_valid && !dev_tx_valid && !dev_rx_ready);
endmodule

bind chain_dma_engine chain_dma_engine_chk #(.AW(AW), .DW(DW), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .mem_valid(mem_valid), .mem_ready(mem_ready),
  .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
  .dev_tx_valid(dev_tx_valid), .dev_tx_ready(dev_tx_ready),
  .dev_tx_data(dev_tx_data), .dev_tx_remain(dev_tx_remain),
  .dev_rx_ready(dev_rx_ready), .busy(busy), .err(err), .start_bit(start_q)
);

// File: tb/tb_chain_dma_engine.sv
`timescale 1ns/1ps
module tb_chain_dma_engine;
  localparam int AW = 24, DW = 32, CNT_W = 8;

  logic clk = 1'b0, rst = 1'b1;
  logic reg_we = 1'b0;
  logic [1:0] reg_sel = 2'd0;
  logic [DW-1:0] reg_wdata = '0, reg_rdata;
  logic mem_valid, mem_ready, mem_we, mem_rvalid;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata, mem_rdata;
  logic dev_tx_valid, dev_tx_ready, dev_rx_ready;
  logic [DW-1:0] dev_tx_data;
  logic [CNT_W-1:0] dev_tx_remain;
  logic [DW-1:0] dev_rx_data;
  logic busy, err;

  always #2 clk = ~clk;

  chain_dma_engine #(.AW(AW), .DW(DW), .CNT_W(CNT_W)) dut (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_valid(mem_valid),
    .mem_ready(mem_ready), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .dev_tx_valid(dev_tx_valid), .dev_tx_ready(dev_tx_ready),
    .dev_tx_data(dev_tx_data), .dev_tx_remain(dev_tx_remain),
    .dev_rx_valid(1'b1), .dev_rx_ready(dev_rx_ready),
    .dev_rx_data(dev_rx_data), .busy(busy), .err(err)
  );

  // memory model, device sink and source
  logic [DW-1:0] mem [1024];
  int cyc = 0, n_cap = 0, src_idx = 0;
  logic [DW-1:0] cap_d [512];
  int cap_r [512];

  assign dev_rx_data = 32'h5A00_0000 + DW'(src_idx);

  always @(posedge clk) begin
    cyc <= cyc + 1;
    mem_ready    <= (cyc % 3) != 0;
    dev_tx_ready <= (cyc % 4) != 1;
    mem_rvalid <= 1'b0;
    if (mem_valid && mem_ready) begin
      if (mem_we) mem[mem_addr[11:2]] <= mem_wdata;
      else begin
        mem_rvalid <= 1'b1;
        mem_rdata  <= mem[mem_addr[11:2]];
      end
    end
    if (dev_tx_valid && dev_tx_ready) begin
      cap_d[n_cap] <= dev_tx_data;
      cap_r[n_cap] <= int'(dev_tx_remain);
      n_cap <= n_cap + 1;
    end
    if (dev_rx_ready) src_idx <= src_idx + 1;
  end

  int n_chk = 0, n_fail = 0;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [1:0] s, input logic [31:0] d);
    @(negedge clk); reg_we = 1'b1; reg_sel = s; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rd_reg(input logic [1:0] s, output logic [31:0] d);
    @(negedge clk); reg_sel = s;
    @(negedge clk); d = reg_rdata;
  endtask

  task automatic wait_done();
    int t = 0;
    repeat (2) @(negedge clk);
    while (busy && t < 20000) begin @(negedge clk); t++; end
    if (busy) check("watchdog busy", 32'(busy), 32'd0);
  endtask

  function automatic logic [31:0] ctl(input int mode, input bit rev, input bit dir);
    return 32'h1100_0000 | (32'(mode) << 9) | (32'(rev) << 1) | 32'(dir);
  endfunction

  typedef struct packed {
    logic [23:0] base;
    logic [7:0]  cnt;
    logic        rev;
  } vec_t;

  localparam vec_t VEC [5] = '{
    '{24'h000100, 8'd4, 1'b0},
    '{24'h000203, 8'd3, 1'b0},
    '{24'h000008, 8'd4, 1'b1},
    '{24'hFF0FF0, 8'd5, 1'b0},
    '{24'h000010, 8'd1, 1'b1}
  };

  initial begin
    #(4 * 190000);
    n_fail++;
    $display("FAIL watchdog expired actual running expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] rv;
    logic [23:0] a;
    int c0, s0;
    for (int i = 0; i < 1024; i++) mem[i] = 32'hD000_0000 + 32'(i);
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // reset state
    check("R2 busy after reset", 32'(busy), 0);
    check("R9 err after reset", 32'(err), 0);
    check("R12 mem_valid after reset", 32'(mem_valid), 0);
    rd_reg(2'd2, rv); check("R1 ctl after reset", rv, 0);

    // R1 base masking
    wr_reg(2'd0, 32'hAB12_3457); rd_reg(2'd0, rv);
    check("R1 base masked", rv, 32'h0012_3457);

    // R10 chopping fields stored, no effect
    wr_reg(2'd2, 32'h0005_0501); rd_reg(2'd2, rv);
    check("R10 chop readback", rv, 32'h0005_0501);
    check("R10 no start", 32'(busy), 0);

    // table of manual memory-to-device vectors (R3, R5)
    for (int v = 0; v < 5; v++) begin
      c0 = n_cap;
      wr_reg(2'd0, 32'(VEC[v].base));
      wr_reg(2'd1, 32'(VEC[v].cnt));
      wr_reg(2'd2, ctl(0, VEC[v].rev, 1'b1));
      wait_done();
      repeat (2) @(negedge clk);
      check("R3 word count", 32'(n_cap - c0), 32'(VEC[v].cnt));
      a = {VEC[v].base[23:2], 2'b00};
      for (int k = 0; k < int'(VEC[v].cnt); k++) begin
        check("R3 data order", cap_d[c0+k], mem[a[11:2]]);
        check("R5 remain", 32'(cap_r[c0+k]), 32'(int'(VEC[v].cnt) - 1 - k));
        a = VEC[v].rev ? a - 24'd4 : a + 24'd4;
      end
      rd_reg(2'd2, rv);
      check("R2 enable and start cleared", rv & 32'h1100_0000, 0);
    end

    // R3 zero count = 2^CNT_W words, with R11 writes during busy
    c0 = n_cap;
    wr_reg(2'd0, 32'h0000_0400);
    wr_reg(2'd1, 32'h0000_0000);
    wr_reg(2'd2, ctl(0, 1'b0, 1'b1));
    @(negedge clk);
    check("R2 busy during run", 32'(busy), 1);
    wr_reg(2'd0, 32'h0012_3450);
    wr_reg(2'd2, 32'h0000_0000);
    wait_done();
    repeat (2) @(negedge clk);
    check("R3 zero count words", 32'(n_cap - c0), 256);
    check("R5 first remain", 32'(cap_r[c0]), 255);
    check("R5 last remain", 32'(cap_r[c0+255]), 0);
    check("R3 last word", cap_d[c0+255], mem[(24'h400 + 24'd1020) >> 2]);
    rd_reg(2'd0, rv); check("R11 base unchanged", rv, 32'h0000_0400);

    // R4 device to memory
    s0 = src_idx;
    wr_reg(2'd0, 32'h0000_0300);
    wr_reg(2'd1, 32'd3);
    wr_reg(2'd2, ctl(0, 1'b0, 1'b0));
    wait_done();
    repeat (2) @(negedge clk);
    for (int k = 0; k < 3; k++)
      check("R4 memory write", mem[(12'h300 >> 2) + k], 32'h5A00_0000 + 32'(s0 + k));

    // R6 R7 R8 linked list, reverse bit set and ignored
    mem[24'h100 >> 2] = {8'd2, 24'h000140};
    mem[24'h140 >> 2] = {8'd0, 24'h000182};
    mem[24'h180 >> 2] = {8'd1, 24'h800FFC};
    c0 = n_cap;
    wr_reg(2'd0, 32'h0000_0100);
    wr_reg(2'd2, ctl(2, 1'b1, 1'b1));
    wait_done();
    repeat (2) @(negedge clk);
    check("R8 list word total", 32'(n_cap - c0), 3);
    check("R6 payload 0", cap_d[c0],   mem[24'h104 >> 2]);
    check("R6 payload 1", cap_d[c0+1], mem[24'h108 >> 2]);
    check("R7 R8 node after empty", cap_d[c0+2], mem[24'h184 >> 2]);
    check("R5 list remain", 32'(cap_r[c0]), 1);
    check("R5 list remain last", 32'(cap_r[c0+2]), 0);
    check("R9 no err list", 32'(err), 0);

    // R9 unsupported modes
    for (int m = 0; m < 3; m++) begin
      c0 = n_cap;
      wr_reg(2'd2, (m == 2) ? ctl(2, 1'b0, 1'b0) : ctl(m == 0 ? 1 : 3, 1'b0, 1'b1));
      wait_done();
      repeat (2) @(negedge clk);
      check("R9 err set", 32'(err), 1);
      check("R9 no words", 32'(n_cap - c0), 0);
      rd_reg(2'd2, rv);
      check("R9 enable cleared", rv & 32'h0100_0000, 0);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule